// File: doc/BRIEF.md
# Script Engine Host Register Block

This block is the host-facing register window of a script-driven transfer engine. A host reaches a 96-byte space through a single byte-wide port with separate read and write strobes. A small set of offsets carries a special meaning: the script pointer, the operand word, the temporary word, the byte count and the command byte. The block assembles each of these from little-endian byte lanes and drives it out as a full-width word for the engine to use. Every other valid offset is an ordinary byte of storage, and it reads back whatever was last written to it.

Some writes act as commands. Writing the most significant byte of the script pointer takes the engine out of its halted state, and it also launches an automatic run unless the mode register selects manual operation. Writing the DMA control byte launches either a single step or a run, depending on two of its bits. The engine signals back through two event inputs, one for a script interrupt and one for a completed step. Each event sets status bits and raises the interrupt line. When the host reads the DMA status byte, it receives the current value, and that read then clears the pending bits and drops the interrupt line.

Top module: `scr_hostregs`

## Requirements
- R1: After reset, offset 0x00 reads 0xC0, 0x0C reads 0x80, 0x0F reads 0x02, 0x18 reads 0xFF, 0x19 reads 0xF0, 0x1A reads 0x01, 0x46 reads 0x60, 0x47 reads 0x0F and 0x4C reads 0x03. Every other offset reads 0x00, all assembled words are zero, and `irq`, `halted`, `run_start` and `step_start` are low.
- R2: A write at an offset from 0x60 up to 0x7F changes no register. A read there returns 0x00.
- R3: The assembled words are little-endian, with the lowest offset holding bits 7:0. The temporary word comes from 0x1C–0x1F, the operand word from 0x30–0x33, and the script pointer from 0x2C–0x2F. The 24-bit count comes from 0x24–0x26 and the command byte from 0x27.
- R4: A write to any valid offset other than 0x0C stores the byte. Reading that offset returns the stored byte.
- R5: A write to 0x2F clears `halted`. If bit 0 of the mode byte at 0x38 is 0 at the time of the write, `run_start` is high for exactly the one cycle after the write edge. If that bit is 1, no start pulse occurs.
- R6: A write to the control byte at 0x3B with bits 4 and 2 both set pulses `step_start` for one cycle. With bit 2 set and bit 4 clear, it pulses `run_start` instead. With bit 2 clear, it pulses neither. The byte always reads back as written.
- R7: A read of 0x0C returns the current status value. On that clock edge, the read then clears bit 0 of the interrupt status byte at 0x14, clears bit 3 of the status byte, and drops `irq`. Bit 2 of the status byte is not cleared.
- R8: `eng_int_set` sets status bit 2, interrupt status bit 0, `halted` and `irq`. `eng_step_done` sets status bit 3, interrupt status bit 0 and `irq`.
- R9: When an engine event arrives on the same edge as a status read, the event's bits and `irq` end up set.
- R10: A host write to 0x0C has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 7 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; side effects take place on the clock edge |
| rd_data | output | 8 | Read byte, combinational from the current offset |
| eng_int_set | input | 1 | Engine executed an interrupt instruction |
| eng_step_done | input | 1 | Engine completed a single step |
| ptr_q | output | 32 | Script pointer |
| operand_q | output | 32 | Operand word |
| temp_q | output | 32 | Temporary word |
| count_q | output | 24 | Byte count |
| cmd_q | output | 8 | Command byte |
| run_start | output | 1 | One-cycle run launch |
| step_start | output | 1 | One-cycle single-step launch |
| halted | output | 1 | Engine halted flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together for the same offset. They also assume that the engine event inputs are single-cycle pulses, and that the unhalt check applies only when no interrupt event arrives on the same edge. The directed stimulus drives every strobe for exactly one cycle and keeps host reads and writes apart. It raises an engine event together with a status read only in the scenario built to test that collision. It never makes a pointer write coincide with an engine event.

// File: rtl/scr_hostregs.sv
module scr_hostregs #(
  parameter int AW    = 7,
  parameter int SPACE = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          eng_int_set,
  input  logic          eng_step_done,
  output logic [31:0]   ptr_q,
  output logic [31:0]   operand_q,
  output logic [31:0]   temp_q,
  output logic [23:0]   count_q,
  output logic [7:0]    cmd_q,
  output logic          run_start,
  output logic          step_start,
  output logic          halted,
  output logic          irq
);
  localparam int OFS_STAT  = 'h0C;
  localparam int OFS_ISTAT = 'h14;
  localparam int OFS_TEMP  = 'h1C;
  localparam int OFS_CNT   = 'h24;
  localparam int OFS_CMD   = 'h27;
  localparam int OFS_PTR   = 'h2C;
  localparam int OFS_OPND  = 'h30;
  localparam int OFS_MODE  = 'h38;
  localparam int OFS_CTL   = 'h3B;

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      'h00: return 8'hC0;
      'h0C: return 8'h80;
      'h0F: return 8'h02;
      'h18: return 8'hFF;
      'h19: return 8'hF0;
      'h1A: return 8'h01;
      'h46: return 8'h60;
      'h47: return 8'h0F;
      'h4C: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] mem [SPACE];
  int  aix;
  logic in_rng, wr_hit, stat_rd;

  assign aix     = int'(acc_addr);
  assign in_rng  = aix < SPACE;
  assign wr_hit  = wr_en && in_rng;
  assign stat_rd = rd_en && aix == OFS_STAT;
  assign rd_data = in_rng ? mem[acc_addr] : 8'h00;

  assign temp_q    = {mem[OFS_TEMP+3], mem[OFS_TEMP+2], mem[OFS_TEMP+1], mem[OFS_TEMP]};
  assign count_q   = {mem[OFS_CNT+2], mem[OFS_CNT+1], mem[OFS_CNT]};
  assign cmd_q     = mem[OFS_CMD];
  assign ptr_q     = {mem[OFS_PTR+3], mem[OFS_PTR+2], mem[OFS_PTR+1], mem[OFS_PTR]};
  assign operand_q = {mem[OFS_OPND+3], mem[OFS_OPND+2], mem[OFS_OPND+1], mem[OFS_OPND]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE; i++) mem[i] <= rst_val(i);
      halted     <= 1'b0;
      irq        <= 1'b0;
      run_start  <= 1'b0;
      step_start <= 1'b0;
    end else begin
      run_start  <= 1'b0;
      step_start <= 1'b0;
      if (wr_hit) begin
        if (aix != OFS_STAT) mem[acc_addr] <= wr_data;
        if (aix == OFS_PTR + 3) begin
          halted <= 1'b0;
          if (!mem[OFS_MODE][0]) run_start <= 1'b1;
        end
        if (aix == OFS_CTL) begin
          if (wr_data[4] && wr_data[2]) step_start <= 1'b1;
          else if (wr_data[2])          run_start  <= 1'b1;
        end
      end
      if (stat_rd) begin
        mem[OFS_ISTAT][0] <= 1'b0;
        mem[OFS_STAT][3]  <= 1'b0;
        irq               <= 1'b0;
      end
      if (eng_int_set) begin
        mem[OFS_ISTAT][0] <= 1'b1;
        mem[OFS_STAT][2]  <= 1'b1;
        halted            <= 1'b1;
        irq               <= 1'b1;
      end
      if (eng_step_done) begin
        mem[OFS_ISTAT][0] <= 1'b1;
        mem[OFS_STAT][3]  <= 1'b1;
        irq               <= 1'b1;
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_start && step_start)); // R6
  AST_STEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> $past(wr_en && aix == OFS_CTL && wr_data[4] && wr_data[2])); // R6
  AST_HIGH_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_rng) |=> ($stable(ptr_q) && $stable(operand_q) && $stable(temp_q) && $stable(count_q))); // R2
  AST_UNHALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aix == OFS_PTR + 3 && !eng_int_set) |=> !halted); // R5
  AST_STAT_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !eng_int_set && !eng_step_done) |=> !irq); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_int_set || eng_step_done) |=> irq); // R9
  AST_STEP_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_start) |-> !step_start || $past(wr_en)); // R6
endmodule

// File: tb/sim_scr_hostregs.sv
module sim_scr_hostregs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  acc_addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        eng_int_set = 1'b0, eng_step_done = 1'b0;
  logic [31:0] ptr_q, operand_q, temp_q;
  logic [23:0] count_q;
  logic [7:0]  cmd_q;
  logic        run_start, step_start, halted, irq;

  int n_chk = 0, n_bad = 0;
  logic rs, ss, after;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  scr_hostregs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); acc_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 rs = run_start; ss = step_start;
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1 after = run_start | step_start;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk); acc_addr = a; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic t_reset;
    rd(7'h00, rv); chk("R1 0x00", rv, 8'hC0);
    rd(7'h0C, rv); chk("R1 0x0C", rv, 8'h80);
    rd(7'h0F, rv); chk("R1 0x0F", rv, 8'h02);
    rd(7'h18, rv); chk("R1 0x18", rv, 8'hFF);
    rd(7'h19, rv); chk("R1 0x19", rv, 8'hF0);
    rd(7'h1A, rv); chk("R1 0x1A", rv, 8'h01);
    rd(7'h46, rv); chk("R1 0x46", rv, 8'h60);
    rd(7'h47, rv); chk("R1 0x47", rv, 8'h0F);
    rd(7'h4C, rv); chk("R1 0x4C", rv, 8'h03);
    rd(7'h2F, rv); chk("R1 0x2F", rv, 8'h00);
    chk("R1 ptr", ptr_q, 0);
    chk("R1 flags", {irq, halted, run_start, step_start}, 0);
  endtask

  task automatic t_range;
    wr(7'h60, 8'h55); wr(7'h7F, 8'hAA);
    rd(7'h60, rv); chk("R2 read 0x60", rv, 8'h00);
    rd(7'h7F, rv); chk("R2 read 0x7F", rv, 8'h00);
    rd(7'h5F, rv); chk("R2 0x5F untouched", rv, 8'h00);
    rd(7'h00, rv); chk("R2 0x00 untouched", rv, 8'hC0);
    rd(7'h20, rv); chk("R2 0x20 untouched", rv, 8'h00);
  endtask

  task automatic t_assemble;
    wr(7'h1C, 8'h11); wr(7'h1D, 8'h22); wr(7'h1E, 8'h33); wr(7'h1F, 8'h44);
    chk("R3 temp", temp_q, 32'h44332211);
    wr(7'h24, 8'h01); wr(7'h25, 8'h02); wr(7'h26, 8'h03);
    chk("R3 count", count_q, 24'h030201);
    wr(7'h27, 8'hC0); chk("R3 cmd", cmd_q, 8'hC0);
    wr(7'h30, 8'hEF); wr(7'h31, 8'hBE); wr(7'h32, 8'hAD); wr(7'h33, 8'hDE);
    chk("R3 operand", operand_q, 32'hDEADBEEF);
    wr(7'h38, 8'h01);
    wr(7'h2C, 8'h00); wr(7'h2D, 8'h10); wr(7'h2E, 8'h20); wr(7'h2F, 8'h30);
    chk("R5 manual no start", {rs, ss}, 0);
    chk("R3 ptr", ptr_q, 32'h30201000);
  endtask

  task automatic t_file;
    wr(7'h50, 8'hA5); rd(7'h50, rv); chk("R4 0x50", rv, 8'hA5);
    wr(7'h19, 8'h3C); rd(7'h19, rv); chk("R4 0x19", rv, 8'h3C);
  endtask

  task automatic t_int_and_start;
    @(negedge clk); eng_int_set = 1'b1; @(negedge clk); eng_int_set = 1'b0;
    chk("R8 halted", halted, 1); chk("R8 irq", irq, 1);
    rd(7'h14, rv); chk("R8 istat", rv, 8'h01);
    rd(7'h0C, rv); chk("R7 stat value", rv, 8'h84);
    chk("R7 irq low", irq, 0);
    rd(7'h14, rv); chk("R7 istat cleared", rv, 8'h00);
    rd(7'h0C, rv); chk("R7 bit2 kept", rv, 8'h84);
    wr(7'h38, 8'h00);
    wr(7'h2F, 8'h31);
    chk("R5 run pulse", {rs, ss}, 2'b10);
    chk("R5 single cycle", after, 0);
    chk("R5 unhalted", halted, 0);
  endtask

  task automatic t_ctl;
    wr(7'h3B, 8'h14); chk("R6 step", {rs, ss}, 2'b01); chk("R6 step single", after, 0);
    wr(7'h3B, 8'h04); chk("R6 run", {rs, ss}, 2'b10);
    wr(7'h3B, 8'h10); chk("R6 none", {rs, ss}, 2'b00);
    rd(7'h3B, rv); chk("R6 readback", rv, 8'h10);
  endtask

  task automatic t_step;
    @(negedge clk); eng_step_done = 1'b1; @(negedge clk); eng_step_done = 1'b0;
    chk("R8 step irq", irq, 1);
    rd(7'h14, rv); chk("R8 step istat", rv, 8'h01);
    rd(7'h0C, rv); chk("R8 step stat", rv, 8'h8C);
    rd(7'h0C, rv); chk("R7 bit3 cleared", rv, 8'h84);
  endtask

  task automatic t_collide;
    @(negedge clk); acc_addr = 7'h0C; rd_en = 1'b1; eng_step_done = 1'b1;
    @(negedge clk); rd_en = 1'b0; eng_step_done = 1'b0;
    chk("R9 irq kept", irq, 1);
    rd(7'h14, rv); chk("R9 istat kept", rv, 8'h01);
    rd(7'h0C, rv); chk("R9 stat kept", rv, 8'h8C);
  endtask

  task automatic t_stat_write;
    wr(7'h0C, 8'h00);
    rd(7'h0C, rv); chk("R10 stat unchanged", rv, 8'h84);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_range();
    t_assemble();
    t_file();
    t_int_and_start();
    t_ctl();
    t_step();
    t_collide();
    t_stat_write();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule